// File: doc/BRIEF.md
# Two-Stage Supply Droop Responder

This block is the digital back end of a supply monitor. Three comparators report, without any clock relation, that the supply has sagged below one of three levels. The highest is a warning level. Below it is a critical level. Lowest is a floor under which the power-on reset circuit holds the chip. The block brings each comparator flag into the clock domain. It answers the warning level with a maskable interrupt request and a status bit that software can poll. It answers the critical level with a reset request that keeps the chip stopped, so flash cannot be altered at an unsafe voltage.

Once the supply falls below the floor, the block stops reporting the reset as its own. It reports that the power-on reset circuit now owns it, and it keeps the reset request up throughout. The comparators have hysteresis, so the flags do not chatter. The block therefore uses a plain synchronizer and no filter. At reset the synchronizer chains start in the "supply bad" state. The block reports a droop until the first clean samples have passed through.

Top module: `bod_response`

## Requirements
- R1: Each comparator input reaches the outputs exactly SYNC_STAGES (default 2) rising clock edges after it changes. After SYNC_STAGES-1 edges the outputs still show the old value.
- R2: `warn_status_o` is 1 while the synchronized warning flag is 1, whatever the value of the interrupt enable.
- R3: `warn_irq_o` is a level that is 1 only when the synchronized warning flag is 1 and the enable bit is 1. It drops when either of them drops.
- R4: A rising edge with `irq_en_we`=1 loads `irq_en_wd` into the enable bit, and `irq_en_q` reads it back. With `irq_en_we`=0 the enable bit keeps its value.
- R5: While `rst_n`=0 the enable bit is 0, `warn_irq_o` is 0, and both `warn_status_o` and `bor_req_o` are 1. After release with all comparator inputs at 0, they clear after SYNC_STAGES edges.
- R6: `bor_req_o` is 1 whenever the synchronized critical flag or the synchronized floor flag is 1. It stays 1 while the supply moves from below the critical level to below the floor.
- R7: `por_owner_o` follows the synchronized floor flag. `bod_owner_o` is 1 only when the critical flag is 1 and the floor flag is 0. The two owner outputs are never 1 together.
- R8: The warning flag alone never raises `bor_req_o`, and the critical flag alone never raises `warn_status_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous system reset |
| warn_cmp_i | input | 1 | Asynchronous flag: supply under the warning level |
| crit_cmp_i | input | 1 | Asynchronous flag: supply under the critical level |
| floor_cmp_i | input | 1 | Asynchronous flag: supply under the power-on-reset floor |
| irq_en_we | input | 1 | Write strobe for the interrupt enable bit |
| irq_en_wd | input | 1 | Value written to the interrupt enable bit |
| irq_en_q | output | 1 | Current interrupt enable bit |
| warn_status_o | output | 1 | Raw synchronized warning flag for polling |
| warn_irq_o | output | 1 | Level interrupt request toward the interrupt controller |
| bor_req_o | output | 1 | Brown-out reset request |
| bod_owner_o | output | 1 | Reset is held by the brown-out stage |
| por_owner_o | output | 1 | Reset is held by the power-on reset circuit |

## Verification
The supply is walked down through all three levels and back up. This shows the warning, critical and floor responses switching on in the right order, and it shows that reset ownership passes to power-on reset without a gap in `bor_req_o`. The warning is applied once with the enable bit clear and once with it set, which separates the polled status path from the interrupt path. The flags are also applied one at a time in inconsistent combinations, such as critical without warning and floor without critical, which exposes any wrong cross-coupling between the three responses. A sample taken one edge early on each input change pins the synchronizer depth, and a sample right after reset release confirms the pessimistic start state.

// File: rtl/bod_pkg.sv
package bod_pkg;

   localparam int unsigned BOD_NFLAGS = 3;

   localparam int unsigned BOD_IDX_WARN  = 0;
   localparam int unsigned BOD_IDX_CRIT  = 1;
   localparam int unsigned BOD_IDX_FLOOR = 2;

   typedef struct packed {
      logic floor;
      logic crit;
      logic warn;
   } bod_flags_t;

   function automatic bod_flags_t bod_pack(input logic w, input logic c, input logic f);
      bod_flags_t r;
      r.warn  = w;
      r.crit  = c;
      r.floor = f;
      return r;
   endfunction

endpackage

// File: rtl/bod_sync.sv
module bod_sync #(
   parameter int unsigned WIDTH   = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("bod_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("bod_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= {WIDTH{RST_VAL}};
            else        chain[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= {WIDTH{RST_VAL}};
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_sync = chain[LAST];

endmodule

// File: rtl/bod_irq_ctrl.sv
module bod_irq_ctrl #(
   parameter bit IRQ_REG = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic warn_sync,
   input  logic en_we,
   input  logic en_wd,
   output logic en_q,
   output logic status,
   output logic irq
);

   logic en_r;
   logic irq_next;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     en_r <= 1'b0;
      else if (en_we) en_r <= en_wd;
   end

   always_comb irq_next = warn_sync & en_r;

   if (IRQ_REG) begin : g_irq_flop
      logic irq_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_r <= 1'b0;
         else        irq_r <= irq_next;
      end
      assign irq = irq_r;
   end else begin : g_irq_comb
      assign irq = irq_next;
   end

   assign en_q   = en_r;
   assign status = warn_sync;

endmodule

// File: rtl/bod_reset_ctrl.sv
module bod_reset_ctrl (
   input  logic crit_sync,
   input  logic floor_sync,
   output logic req,
   output logic bod_owner,
   output logic por_owner
);

   always_comb begin
      por_owner = floor_sync;
      bod_owner = crit_sync & ~floor_sync;
      req       = crit_sync | floor_sync;
   end

endmodule

// File: rtl/bod_response.sv
module bod_response #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IRQ_REG     = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic warn_cmp_i,
   input  logic crit_cmp_i,
   input  logic floor_cmp_i,
   input  logic irq_en_we,
   input  logic irq_en_wd,
   output logic irq_en_q,
   output logic warn_status_o,
   output logic warn_irq_o,
   output logic bor_req_o,
   output logic bod_owner_o,
   output logic por_owner_o
);
   import bod_pkg::*;

   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("bod_response: SYNC_STAGES must be at least 2");
   end

   bod_flags_t raw_flags;
   bod_flags_t sync_flags;

   assign raw_flags = bod_pack(warn_cmp_i, crit_cmp_i, floor_cmp_i);

   bod_sync #(
      .WIDTH  (BOD_NFLAGS),
      .STAGES (SYNC_STAGES),
      .RST_VAL(1'b1)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_async(raw_flags),
      .q_sync (sync_flags)
   );

   bod_irq_ctrl #(
      .IRQ_REG(IRQ_REG)
   ) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .warn_sync(sync_flags.warn),
      .en_we    (irq_en_we),
      .en_wd    (irq_en_wd),
      .en_q     (irq_en_q),
      .status   (warn_status_o),
      .irq      (warn_irq_o)
   );

   bod_reset_ctrl u_rst (
      .crit_sync (sync_flags.crit),
      .floor_sync(sync_flags.floor),
      .req       (bor_req_o),
      .bod_owner (bod_owner_o),
      .por_owner (por_owner_o)
   );

endmodule

// File: rtl/bod_response_chk.sv
module bod_response_chk (
   input logic clk,
   input logic rst_n,
   input logic irq_en_we,
   input logic irq_en_wd,
   input logic irq_en_q,
   input logic warn_status_o,
   input logic warn_irq_o,
   input logic bor_req_o,
   input logic bod_owner_o,
   input logic por_owner_o
);

   assert_en_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      irq_en_we |=> (irq_en_q == $past(irq_en_wd)));

   assert_en_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_we |=> $stable(irq_en_q));

   assert_irq_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
      warn_irq_o |-> (warn_status_o && irq_en_q));

   assert_owner_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(bod_owner_o && por_owner_o));

   assert_owner_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (bod_owner_o || por_owner_o) |-> bor_req_o);

   assert_handoff_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bod_owner_o) && por_owner_o |-> bor_req_o);

endmodule

bind bod_response bod_response_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .irq_en_we    (irq_en_we),
   .irq_en_wd    (irq_en_wd),
   .irq_en_q     (irq_en_q),
   .warn_status_o(warn_status_o),
   .warn_irq_o   (warn_irq_o),
   .bor_req_o    (bor_req_o),
   .bod_owner_o  (bod_owner_o),
   .por_owner_o  (por_owner_o)
);

// File: tb/bod_response_test.sv
module bod_response_test;

   localparam int unsigned NSYNC = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b1;
   logic warn = 1'b0, crit = 1'b0, flr = 1'b0;
   logic en_we = 1'b0, en_wd = 1'b0;
   logic en_q, status, irq, req, bown, pown;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   bod_response #(.SYNC_STAGES(NSYNC), .IRQ_REG(1'b0)) uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .warn_cmp_i   (warn),
      .crit_cmp_i   (crit),
      .floor_cmp_i  (flr),
      .irq_en_we    (en_we),
      .irq_en_wd    (en_wd),
      .irq_en_q     (en_q),
      .warn_status_o(status),
      .warn_irq_o   (irq),
      .bor_req_o    (req),
      .bod_owner_o  (bown),
      .por_owner_o  (pown)
   );

   task automatic check(input string req_tag, input string what, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %b expected %b", req_tag, what, act, exp);
      end
   endtask

   task automatic steps(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_flags(input logic w, input logic c, input logic f);
      warn = w; crit = c; flr = f;
   endtask

   task automatic write_en(input logic v);
      en_we = 1'b1; en_wd = v;
      steps(1);
      en_we = 1'b0; en_wd = 1'b0;
   endtask

   // expected outputs from supply flags and enable (R2, R3, R6, R7)
   task automatic expect_all(input string tag, input logic w, input logic c, input logic f, input logic e);
      check(tag, "status", status, w);
      check(tag, "irq",    irq,    w & e);
      check(tag, "req",    req,    c | f);
      check(tag, "bod_owner", bown, c & ~f);
      check(tag, "por_owner", pown, f);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      set_flags(0, 0, 0);
      steps(3);
      check("R5", "en in reset", en_q, 1'b0);
      check("R5", "irq in reset", irq, 1'b0);
      check("R5", "status in reset", status, 1'b1);
      check("R5", "req in reset", req, 1'b1);
      rst_n = 1'b1;
      steps(NSYNC - 1);
      check("R5", "req one edge after release", req, 1'b1);
      steps(1);
      check("R5", "req cleared", req, 1'b0);
      check("R5", "status cleared", status, 1'b0);
   endtask

   task automatic t_enable_rw();
      write_en(1'b1);
      check("R4", "en written 1", en_q, 1'b1);
      steps(3);
      check("R4", "en held", en_q, 1'b1);
      write_en(1'b0);
      check("R4", "en written 0", en_q, 1'b0);
   endtask

   task automatic t_warn_polled();
      set_flags(1, 0, 0);
      steps(NSYNC);
      check("R2", "status with en=0", status, 1'b1);
      check("R3", "irq masked", irq, 1'b0);
      check("R8", "warn alone no req", req, 1'b0);
      set_flags(0, 0, 0);
      steps(NSYNC);
      check("R2", "status released", status, 1'b0);
   endtask

   task automatic t_warn_irq();
      write_en(1'b1);
      set_flags(1, 0, 0);
      steps(NSYNC - 1);
      check("R1", "irq not yet", irq, 1'b0);
      steps(1);
      check("R3", "irq raised", irq, 1'b1);
      write_en(1'b0);
      check("R3", "irq drops with enable", irq, 1'b0);
      check("R2", "status kept", status, 1'b1);
      write_en(1'b1);
      set_flags(0, 0, 0);
      steps(NSYNC);
      check("R3", "irq drops with flag", irq, 1'b0);
   endtask

   task automatic t_walk_down_up();
      // enable still 1 from previous task
      set_flags(1, 0, 0); steps(NSYNC); expect_all("R6", 1, 0, 0, 1);
      set_flags(1, 1, 0);
      steps(NSYNC - 1);
      check("R1", "req one edge early", req, 1'b0);
      steps(1);
      expect_all("R6", 1, 1, 0, 1);
      set_flags(1, 1, 1);
      for (int i = 0; i < NSYNC; i++) begin
         steps(1);
         check("R6", "req through handoff", req, 1'b1);
      end
      expect_all("R7", 1, 1, 1, 1);
      set_flags(1, 1, 0);
      for (int i = 0; i < NSYNC; i++) begin
         steps(1);
         check("R6", "req through return", req, 1'b1);
      end
      expect_all("R7", 1, 1, 0, 1);
      set_flags(0, 0, 0); steps(NSYNC); expect_all("R6", 0, 0, 0, 1);
   endtask

   task automatic t_odd_combos();
      set_flags(0, 1, 0); steps(NSYNC);
      check("R8", "crit alone no status", status, 1'b0);
      expect_all("R8", 0, 1, 0, 1);
      set_flags(0, 0, 1); steps(NSYNC);
      expect_all("R7", 0, 0, 1, 1);
      set_flags(0, 0, 0); steps(NSYNC);
      expect_all("R1", 0, 0, 0, 1);
   endtask

   initial begin
      steps(1);
      t_reset();
      t_enable_rw();
      t_warn_polled();
      t_warn_irq();
      t_walk_down_up();
      t_odd_combos();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
         end
      join_any
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule